// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This block is the interrupt-handling front end of a simple 32-bit processor core. It watches a set of level-sensitive device request lines. It keeps a processor status word whose bit 0 is the global interrupt enable. It also keeps a shadow copy of that word, a per-source accept mask and a live pending view. At each instruction boundary the core reports, the unit decides whether to break into the running program. If it does, it pulses a take strobe. It stores the address of the next instruction in an internal link register and steers the program counter to a fixed handler address.

A return-from-interrupt strobe reloads the status word from its shadow copy and steers the program counter back to the link value. The core reaches the four control registers only through dedicated control-move operations. These arrive here as a single-address write port and a combinational read port. Instruction execution, the stack and the general registers belong to the core.

Top module: `irqUnit`

## Requirements
- R1: After reset, the status word, saved status, accept mask and link register are all zero, and takeIrq stays low even when every request line is high and instrDone is asserted.
- R2: takeIrq is high in a cycle exactly when instrDone is high, status bit 0 is 1, eretStrobe is low, and at least one source k has irqLines[k] and mask bit k both set. With instrDone low, no interrupt is taken. Source k uses bit k in the mask and in the pending view (for example, a keyboard on bit 1 has value 2 and a display on bit 2 has value 4).
- R3: In the cycle takeIrq is high, redirectEn is high and redirectPc equals the HANDLER_PC parameter. On that clock edge, the link register captures nextPc, the address of the instruction after the one just completed.
- R4: On the entry edge, the saved status receives the old status word. The status word then has bit 0 cleared and all its other bits unchanged.
- R5: While eretStrobe is high, redirectEn is high and redirectPc equals the link register. On that edge, the status word is reloaded from the saved status.
- R6: A request line held high after entry causes no second takeIrq until status bit 0 is set again, either by return or by a control write.
- R7: When eretStrobe and a takeable request meet in the same cycle, the return wins: takeIrq stays low and redirectPc is the link value.
- R8: Control address map on csrAddr: 0 = status word, 1 = saved status, 2 = accept mask, 3 = pending view. A write with csrWrEn high takes effect on the next edge. csrRdData shows the addressed register combinationally.
- R9: The pending view reads irqLines AND the accept mask, with zeros above NSRC. Writes to address 3 have no effect.
- R10: A control write to the status word or to the saved status in the entry cycle loses to the entry sequence. A control write to the status word in a return cycle loses to the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | NSRC | Level-sensitive device requests |
| instrDone | input | 1 | Instruction-boundary strobe |
| nextPc | input | 32 | Address of the following instruction |
| eretStrobe | input | 1 | Return-from-interrupt strobe |
| csrWrEn | input | 1 | Control-register write enable |
| csrAddr | input | 2 | Control-register select for read and write |
| csrWrData | input | 32 | Control-register write data |
| csrRdData | output | 32 | Control-register read data |
| takeIrq | output | 1 | One-cycle interrupt entry pulse |
| redirectEn | output | 1 | Program counter must be reloaded |
| redirectPc | output | 32 | New program counter value |

## Verification
The bench uses an eight-source configuration. It sweeps every request pattern against several mask values with the global enable both on and off, both off and on an instruction boundary. A decoder that ignored the boundary, the enable or the mask would show a wrong takeIrq or a wrong pending readback. A design whose entry lost to a same-cycle control write would leave interrupts enabled. Such a design would retrigger on a held request, and the bench catches that. A design that gave entry priority over return would take a fresh interrupt while returning. The bench also checks that the return target is the captured link value.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int XLEN   = 32;
  localparam int IE_BIT = 0;

  typedef enum logic [1:0] {
    CSR_STATUS = 2'd0,
    CSR_SAVED  = 2'd1,
    CSR_MASK   = 2'd2,
    CSR_PEND   = 2'd3
  } csrSel_t;

  typedef struct packed {
    logic entry;
    logic ret;
    logic wrStatus;
    logic wrSaved;
    logic wrMask;
  } irqStrobes_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrDone,
  input  logic            eretStrobe,
  input  logic            csrWrEn,
  input  logic [1:0]      csrAddr,
  input  logic            ieNow,
  input  logic [XLEN-1:0] pendView,
  input  logic [XLEN-1:0] linkPc,
  output irqStrobes_t     strb,
  output logic            takeIrq,
  output logic            redirectEn,
  output logic [XLEN-1:0] redirectPc
);
  logic    anyPend;
  csrSel_t sel;

  assign anyPend = |pendView;
  assign sel     = csrSel_t'(csrAddr);

  always_comb begin
    strb          = '0;
    strb.ret      = eretStrobe;
    strb.entry    = instrDone && ieNow && anyPend && !eretStrobe;
    strb.wrStatus = csrWrEn && (sel == CSR_STATUS) && !strb.entry && !strb.ret;
    strb.wrSaved  = csrWrEn && (sel == CSR_SAVED) && !strb.entry;
    strb.wrMask   = csrWrEn && (sel == CSR_MASK);
  end

  assign takeIrq    = strb.entry;
  assign redirectEn = strb.entry || strb.ret;
  assign redirectPc = strb.entry ? HANDLER_PC : linkPc;

  AST_ENTRY_RET_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.entry && strb.ret)); // R7
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq); // R6
endmodule

// File: rtl/irqRegs.sv
module irqRegs
  import irqPkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  irqStrobes_t     strb,
  input  logic [NSRC-1:0] irqLines,
  input  logic [XLEN-1:0] nextPc,
  input  logic [XLEN-1:0] csrWrData,
  input  logic [1:0]      csrAddr,
  output logic [XLEN-1:0] csrRdData,
  output logic            ieNow,
  output logic [XLEN-1:0] pendView,
  output logic [XLEN-1:0] linkPc
);
  logic [XLEN-1:0] statusQ, savedQ, maskQ, linkQ;

  for (genvar k = 0; k < XLEN; k++) begin : g_pend
    if (k < NSRC) begin : g_live
      assign pendView[k] = irqLines[k] & maskQ[k];
    end else begin : g_none
      assign pendView[k] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      savedQ  <= '0;
      maskQ   <= '0;
      linkQ   <= '0;
    end else begin
      if (strb.entry) begin
        linkQ           <= nextPc;
        savedQ          <= statusQ;
        statusQ[IE_BIT] <= 1'b0;
      end else if (strb.ret) begin
        statusQ <= savedQ;
      end else if (strb.wrStatus) begin
        statusQ <= csrWrData;
      end
      if (strb.wrSaved) savedQ <= csrWrData;
      if (strb.wrMask)  maskQ  <= csrWrData;
    end
  end

  always_comb begin
    unique case (csrSel_t'(csrAddr))
      CSR_STATUS: csrRdData = statusQ;
      CSR_SAVED:  csrRdData = savedQ;
      CSR_MASK:   csrRdData = maskQ;
      default:    csrRdData = pendView;
    endcase
  end

  assign ieNow  = statusQ[IE_BIT];
  assign linkPc = linkQ;

  AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    strb.entry |=> !statusQ[IE_BIT] && savedQ == $past(statusQ)); // R4
  AST_LINK_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.entry |=> linkQ == $past(nextPc)); // R3
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    strb.ret |=> statusQ == $past(savedQ)); // R5
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.entry && !strb.ret && !strb.wrStatus) |=> $stable(statusQ)); // R10
endmodule

// File: rtl/irqUnit.sv
module irqUnit
  import irqPkg::*;
#(
  parameter int NSRC = 32,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] irqLines,
  input  logic            instrDone,
  input  logic [31:0]     nextPc,
  input  logic            eretStrobe,
  input  logic            csrWrEn,
  input  logic [1:0]      csrAddr,
  input  logic [31:0]     csrWrData,
  output logic [31:0]     csrRdData,
  output logic            takeIrq,
  output logic            redirectEn,
  output logic [31:0]     redirectPc
);
  irqStrobes_t     strb;
  logic            ieNow;
  logic [XLEN-1:0] pendView, linkPc;

  irqCtrl #(.HANDLER_PC(HANDLER_PC)) i_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .eretStrobe(eretStrobe),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .ieNow(ieNow), .pendView(pendView),
    .linkPc(linkPc), .strb(strb), .takeIrq(takeIrq), .redirectEn(redirectEn),
    .redirectPc(redirectPc)
  );

  irqRegs #(.NSRC(NSRC)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .irqLines(irqLines), .nextPc(nextPc),
    .csrWrData(csrWrData), .csrAddr(csrAddr), .csrRdData(csrRdData),
    .ieNow(ieNow), .pendView(pendView), .linkPc(linkPc)
  );

  AST_TAKE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> instrDone && !eretStrobe && (|irqLines)); // R2
endmodule

// File: tb/test_irqUnit.sv
module test_irqUnit;
  localparam int NSRC = 8;
  localparam logic [31:0] HPC = 32'h0000_0080;

  logic clk = 0, rstN = 0;
  logic [NSRC-1:0] irqLines = '0;
  logic instrDone = 0, eretStrobe = 0, csrWrEn = 0;
  logic [31:0] nextPc = '0, csrWrData = '0;
  logic [1:0] csrAddr = '0;
  logic [31:0] csrRdData, redirectPc;
  logic takeIrq, redirectEn;
  int nTests = 0, nFail = 0;
  bit finished = 0;

  irqUnit #(.NSRC(NSRC), .HANDLER_PC(HPC)) i_irqUnit (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csrWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csrAddr = a; csrWrData = d; csrWrEn = 1;
    @(negedge clk); csrWrEn = 0;
  endtask

  task automatic csrCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); csrAddr = a; #2;
    chk(csrRdData === exp, req, csrRdData, exp);
  endtask

  task automatic finish();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish();
    end
  end

  initial begin
    logic [7:0] masks [4] = '{8'h00, 8'h06, 8'hFF, 8'h81};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    csrCheck(2'd0, 32'h0, "R1 status");
    csrCheck(2'd1, 32'h0, "R1 saved");
    csrCheck(2'd2, 32'h0, "R1 mask");
    @(negedge clk); irqLines = '1; instrDone = 1; #2;
    chk(takeIrq === 1'b0, "R1 take", {31'b0, takeIrq}, 0);
    instrDone = 0; irqLines = '0;

    // R2/R9 sweep: patterns x masks x enable, inside one low half-cycle each
    for (int ie = 0; ie < 2; ie++) begin
      csrWrite(2'd0, ie);
      for (int m = 0; m < 4; m++) begin
        csrWrite(2'd2, {24'b0, masks[m]});
        for (int p = 0; p < 256; p++) begin
          logic expT;
          @(negedge clk); irqLines = p[7:0]; csrAddr = 2'd3; instrDone = 0; #2;
          chk(takeIrq === 1'b0, "R2 no boundary", {31'b0, takeIrq}, 0);
          chk(csrRdData === {24'b0, p[7:0] & masks[m]}, "R9 pending", csrRdData, {24'b0, p[7:0] & masks[m]});
          instrDone = 1; #2;
          expT = (ie == 1) && ((p[7:0] & masks[m]) != 0);
          chk(takeIrq === expT && redirectEn === expT, "R2 take", {31'b0, takeIrq}, {31'b0, expT});
          instrDone = 0;
        end
      end
    end
    irqLines = '0;

    // R9 write to pending ignored
    csrWrite(2'd2, 32'h06);
    csrWrite(2'd3, 32'hFFFF_FFFF);
    @(negedge clk); irqLines = 8'h02; csrAddr = 2'd3; #2;
    chk(csrRdData === 32'h2, "R9 write ignored", csrRdData, 32'h2);
    csrCheck(2'd2, 32'h06, "R8 mask readback");

    // R3/R4/R10 entry with competing status write
    csrWrite(2'd0, 32'h5);
    @(negedge clk); nextPc = 32'h1234; instrDone = 1;
    csrWrEn = 1; csrAddr = 2'd0; csrWrData = 32'hFFFF_FFFF; #2;
    chk(takeIrq === 1'b1, "R3 take", {31'b0, takeIrq}, 1);
    chk(redirectEn === 1'b1 && redirectPc === HPC, "R3 handler", redirectPc, HPC);
    @(negedge clk); csrWrEn = 0; instrDone = 0;
    csrCheck(2'd0, 32'h4, "R4/R10 status after entry");
    csrCheck(2'd1, 32'h5, "R4 saved");
    // R6 held request does not retrigger
    @(negedge clk); instrDone = 1; #2;
    chk(takeIrq === 1'b0, "R6 retrigger", {31'b0, takeIrq}, 0);
    instrDone = 0;

    // R5 return, with status write losing (R10)
    @(negedge clk); eretStrobe = 1; csrWrEn = 1; csrAddr = 2'd0; csrWrData = 32'hA0; #2;
    chk(redirectEn === 1'b1 && redirectPc === 32'h1234, "R5 return target", redirectPc, 32'h1234);
    @(negedge clk); eretStrobe = 0; csrWrEn = 0;
    csrCheck(2'd0, 32'h5, "R5/R10 status restored");

    // R7 return beats a takeable request
    @(negedge clk); eretStrobe = 1; instrDone = 1; #2;
    chk(takeIrq === 1'b0, "R7 take suppressed", {31'b0, takeIrq}, 0);
    chk(redirectPc === 32'h1234, "R7 target", redirectPc, 32'h1234);
    @(negedge clk); eretStrobe = 0; instrDone = 0;

    // R10 entry beats saved-status write; R3 new link
    @(negedge clk); nextPc = 32'h2000; instrDone = 1;
    csrWrEn = 1; csrAddr = 2'd1; csrWrData = 32'hDEAD; #2;
    chk(takeIrq === 1'b1, "R2 second take", {31'b0, takeIrq}, 1);
    @(negedge clk); csrWrEn = 0; instrDone = 0;
    csrCheck(2'd1, 32'h5, "R10 saved kept");
    // R6 software re-enable allows a new take
    csrWrite(2'd0, 32'h1);
    @(negedge clk); instrDone = 1; #2;
    chk(takeIrq === 1'b1, "R6 re-enable take", {31'b0, takeIrq}, 1);
    @(negedge clk); instrDone = 0; irqLines = '0;
    // R8 saved readback and return with cleared IE
    csrWrite(2'd1, 32'hC0);
    csrCheck(2'd1, 32'hC0, "R8 saved write");
    @(negedge clk); eretStrobe = 1; #2;
    chk(redirectPc === 32'h2000, "R3 link updated", redirectPc, 32'h2000);
    @(negedge clk); eretStrobe = 0;
    csrCheck(2'd0, 32'hC0, "R5 restore IE=0");

    finished = 1;
    finish();
  end
endmodule